// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block decides, for every CPU-side memory address, whether the access belongs to one of the bridge's outbound windows into PCI memory space. The top 256 MB of the 32-bit address space (top nibble 0xF) is cut into 32 chunks of 8 MB each. A 32-bit chunk-enable register holds one bit per chunk. A 2-bit mode field in a control register switches all forwarding on or off. The decode is combinational. It returns a hit flag, the chunk number and the PCI address, which is the CPU address passed through unchanged. The first chunk is reserved for firmware and the last for the bridge's own registers, so neither can ever forward, whatever their enable bits hold.

The same block also sorts inbound bus-master addresses into one of four regions: system RAM, PCI memory (the thirty forwardable chunks), the CPU region, or none. It reports that region as a 2-bit code with a separate miss flag. Both registers are loaded through a single write strobe with a select bit, and both reset to zero.

Top module: `win_decoder`

## Requirements
- R1: After reset both registers read as zero, so no CPU address produces a hit until software writes them.
- R2: A CPU address hits when its bits [31:28] are 0xF, forwarding is on, and the enable bit of its chunk is set. The chunk is bits [27:23] and must lie in 1..30. On a hit, out_chunk equals bits [27:23].
- R3: Forwarding is on only when control register bits [8:7] equal 2'b01. The values 00, 10 and 11 disable every chunk.
- R4: Chunks 0 and 31 never hit, even with their enable bits (bit 0 and bit 31) set.
- R5: A CPU address whose bits [31:28] differ from 0xF never hits.
- R6: out_pci_addr always equals cpu_addr.
- R7: A write takes effect at the clock edge that samples cfg_wr. cfg_sel=0 loads the enable register and cfg_sel=1 loads the control register. The register that is not selected keeps its value, and the decode uses the new value from the next cycle on.
- R8: Inbound addresses below 0xF0800000 give bm_region 2'b00 (system RAM).
- R9: Inbound addresses from 0xF0800000 to 0xFF7FFFFF give bm_region 2'b01 (PCI memory).
- R10: Inbound addresses from 0xFFF00000 to 0xFFFFFFFE give bm_region 2'b10 (CPU region).
- R11: Every other inbound address (0xFF800000 to 0xFFEFFFFF, and 0xFFFFFFFF) gives bm_region 2'b11. bm_miss is high exactly when bm_region is 2'b11.
- R12: When out_hit is low, out_chunk is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the chunk-enable register, 1 selects the control register |
| cfg_wdata | input | 32 | Write data |
| cpu_addr | input | 32 | CPU-side address to decode |
| out_hit | output | 1 | Address is forwarded to PCI |
| out_chunk | output | 5 | Chunk number of the hit, zero on a miss |
| out_pci_addr | output | 32 | PCI memory address (identity) |
| bm_addr | input | 32 | Inbound bus-master address |
| bm_region | output | 2 | 00 RAM, 01 PCI memory, 10 CPU region, 11 none |
| bm_miss | output | 1 | Inbound address falls in no region |

## Verification
Outbound decoding is tried with all four mode values, with enable masks that are random, all ones and single-bit, and with addresses that are biased into the 0xF nibble, plus uniformly random addresses. Together these separate the mode gate, the per-chunk enables and the exclusion of the edge chunks from the top-nibble test. Inbound decoding is driven with random addresses and with the exact first and last address of each region, plus the addresses one past each boundary, so that an off-by-one at any limit shows up. Writes to one register are followed by checks that the other register is unchanged.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;
    localparam int ADDR_W      = 32;
    localparam int CHUNK_BITS  = 5;
    localparam int N_CHUNKS    = 1 << CHUNK_BITS;
    localparam int CHUNK_LSB   = 23;
    localparam int NIB_W       = ADDR_W - CHUNK_LSB - CHUNK_BITS;
    localparam int MODE_LSB    = 7;
    localparam int MODE_W      = 2;

    localparam logic [NIB_W-1:0]  WIN_NIB   = '1;
    localparam logic [MODE_W-1:0] MODE_FWD  = 2'b01;
    localparam logic [ADDR_W-1:0] CHUNK_SZ  = ADDR_W'(1) << CHUNK_LSB;
    localparam logic [ADDR_W-1:0] WIN_BASE  = {WIN_NIB, {(ADDR_W-NIB_W){1'b0}}};
    localparam logic [ADDR_W-1:0] PCI_LO    = WIN_BASE + CHUNK_SZ;
    localparam logic [ADDR_W-1:0] PCI_END   = WIN_BASE + ADDR_W'(N_CHUNKS - 1) * CHUNK_SZ;
    localparam logic [ADDR_W-1:0] CPU_LO    = 32'hFFF0_0000;
    localparam logic [ADDR_W-1:0] CPU_HI    = 32'hFFFF_FFFE;

    typedef enum logic [1:0] {
        RGN_RAM  = 2'b00,
        RGN_PCI  = 2'b01,
        RGN_CPU  = 2'b10,
        RGN_NONE = 2'b11
    } bm_region_e;

    typedef struct packed {
        logic                  hit;
        logic [CHUNK_BITS-1:0] chunk;
        logic [ADDR_W-1:0]     pci_addr;
    } out_dec_t;

    function automatic logic [CHUNK_BITS-1:0] chunk_of(input logic [ADDR_W-1:0] a);
        return a[CHUNK_LSB +: CHUNK_BITS];
    endfunction
endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import win_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] en_q,
    output logic [ADDR_W-1:0] ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            if (sel) ctrl_q <= wdata;
            else     en_q   <= wdata;
        end
    end
endmodule

// File: rtl/win_out_decode.sv
module win_out_decode
    import win_dec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] en_q,
    input  logic [ADDR_W-1:0] ctrl_q,
    output out_dec_t          dec
);
    logic [N_CHUNKS-1:0] usable;
    logic                fwd_on;
    logic                in_win;
    logic [CHUNK_BITS-1:0] idx;

    // The first and last chunk are reserved and never forward.
    for (genvar i = 0; i < N_CHUNKS; i++) begin : g_usable
        if (i == 0 || i == N_CHUNKS - 1) begin : g_rsvd
            assign usable[i] = 1'b0;
        end else begin : g_open
            assign usable[i] = en_q[i];
        end
    end

    assign fwd_on = (ctrl_q[MODE_LSB +: MODE_W] == MODE_FWD);
    assign in_win = (addr[ADDR_W-1 -: NIB_W] == WIN_NIB);
    assign idx    = chunk_of(addr);

    always_comb begin
        dec.pci_addr = addr;
        dec.hit      = fwd_on && in_win && usable[idx];
        dec.chunk    = dec.hit ? idx : '0;
    end
endmodule

// File: rtl/win_in_decode.sv
module win_in_decode
    import win_dec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output bm_region_e        region
);
    always_comb begin
        if (addr < PCI_LO)
            region = RGN_RAM;
        else if (addr < PCI_END)
            region = RGN_PCI;
        else if (addr >= CPU_LO && addr <= CPU_HI)
            region = RGN_CPU;
        else
            region = RGN_NONE;
    end
endmodule

// File: rtl/win_decoder.sv
module win_decoder
    import win_dec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic [31:0] cpu_addr,
    output logic        out_hit,
    output logic [4:0]  out_chunk,
    output logic [31:0] out_pci_addr,
    input  logic [31:0] bm_addr,
    output logic [1:0]  bm_region,
    output logic        bm_miss
);
    logic [ADDR_W-1:0] en_q;
    logic [ADDR_W-1:0] ctrl_q;
    out_dec_t          odec;
    bm_region_e        rgn;

    win_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .en_q   (en_q),
        .ctrl_q (ctrl_q)
    );

    win_out_decode u_out (
        .addr   (cpu_addr),
        .en_q   (en_q),
        .ctrl_q (ctrl_q),
        .dec    (odec)
    );

    win_in_decode u_in (
        .addr   (bm_addr),
        .region (rgn)
    );

    assign out_hit      = odec.hit;
    assign out_chunk    = odec.chunk;
    assign out_pci_addr = odec.pci_addr;
    assign bm_region    = rgn;
    assign bm_miss      = (rgn == RGN_NONE);
endmodule

// File: rtl/win_decoder_chk.sv
module win_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic        cfg_sel,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cpu_addr,
    input logic        out_hit,
    input logic [4:0]  out_chunk,
    input logic [31:0] out_pci_addr,
    input logic [1:0]  bm_region,
    input logic        bm_miss,
    input logic [31:0] en_q,
    input logic [31:0] ctrl_q
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (en_q == 32'd0 && ctrl_q == 32'd0));

    // R3
    mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[8:7] != 2'b01) |-> !out_hit);

    // R4
    edge_chunk_chk: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (out_chunk != 5'd0 && out_chunk != 5'd31));

    // R5
    nibble_chk: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (cpu_addr[31:28] == 4'hF));

    // R6
    identity_chk: assert property (@(posedge clk) disable iff (rst)
        out_pci_addr == cpu_addr);

    // R7
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_sel) |=> (en_q == $past(cfg_wdata) && $stable(ctrl_q)));

    // R7
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_sel) |=> (ctrl_q == $past(cfg_wdata) && $stable(en_q)));

    // R11
    miss_code_chk: assert property (@(posedge clk) disable iff (rst)
        bm_miss == (bm_region == 2'b11));

    // R12
    chunk_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_hit |-> (out_chunk == 5'd0));
endmodule

bind win_decoder win_decoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wr       (cfg_wr),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .cpu_addr     (cpu_addr),
    .out_hit      (out_hit),
    .out_chunk    (out_chunk),
    .out_pci_addr (out_pci_addr),
    .bm_region    (bm_region),
    .bm_miss      (bm_miss),
    .en_q         (en_q),
    .ctrl_q       (ctrl_q)
);

// File: tb/tb_win_decoder.sv
`timescale 1ns/1ps
module tb_win_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cpu_addr = '0;
    logic        out_hit;
    logic [4:0]  out_chunk;
    logic [31:0] out_pci_addr;
    logic [31:0] bm_addr = '0;
    logic [1:0]  bm_region;
    logic        bm_miss;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_en = '0;
    logic [31:0] m_ctrl = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    win_decoder dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .out_hit(out_hit),
        .out_chunk(out_chunk), .out_pci_addr(out_pci_addr),
        .bm_addr(bm_addr), .bm_region(bm_region), .bm_miss(bm_miss)
    );

    function automatic bit exp_hit(input logic [31:0] a);
        int c = int'(a[27:23]);
        return (m_ctrl[8:7] == 2'b01) && (a[31:28] == 4'hF) &&
               (c != 0) && (c != 31) && m_en[c];
    endfunction

    function automatic logic [1:0] exp_rgn(input logic [31:0] a);
        if (a < 32'hF080_0000) return 2'b00;
        if (a <= 32'hFF7F_FFFF) return 2'b01;
        if (a >= 32'hFFF0_0000 && a <= 32'hFFFF_FFFE) return 2'b10;
        return 2'b11;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input bit sel, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        if (sel) m_ctrl = d; else m_en = d;
    endtask

    task automatic probe_out(input logic [31:0] a, input string req);
        bit eh;
        cpu_addr = a;
        @(negedge clk);
        eh = exp_hit(a);
        check(out_hit == eh, req, 32'(out_hit), 32'(eh));
        check(out_chunk == (eh ? a[27:23] : 5'd0), req, 32'(out_chunk),
              32'(eh ? a[27:23] : 5'd0));
        check(out_pci_addr == a, "R6", out_pci_addr, a);
    endtask

    task automatic probe_in(input logic [31:0] a, input string req);
        logic [1:0] er;
        bm_addr = a;
        @(negedge clk);
        er = exp_rgn(a);
        check(bm_region == er, req, 32'(bm_region), 32'(er));
        check(bm_miss == (er == 2'b11), "R11", 32'(bm_miss), 32'(er == 2'b11));
    endtask

    function automatic logic [31:0] rnd_addr();
        logic [31:0] r = $urandom;
        case ($urandom % 4)
            0: return r;
            1: return {4'hF, r[27:0]};
            2: return {4'hF, 5'd0, r[22:0]};
            default: return {4'hF, 5'd31, r[22:0]};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state, mode off and enables zero
        m_en = '0; m_ctrl = '0;
        probe_out(32'hF080_0000, "R1");
        probe_out(32'hF400_1234, "R1");

        // R7: enable write leaves mode off -> still no hit
        wr_reg(1'b0, 32'hFFFF_FFFF);
        probe_out(32'hF100_0000, "R7");
        // R2: mode on, all enables set
        wr_reg(1'b1, 32'h0000_0080);
        probe_out(32'hF080_0000, "R2");
        probe_out(32'hFF7F_FFFF, "R2");
        // R4: edge chunks never hit
        probe_out(32'hF07F_FFFF, "R4");
        probe_out(32'hFF80_0000, "R4");
        probe_out(32'hFFFF_FFFF, "R4");
        // R5: outside window
        probe_out(32'hE100_0000, "R5");
        probe_out(32'h0080_0000, "R5");
        // R3: each disabling mode value
        for (int mv = 0; mv < 4; mv++) begin
            wr_reg(1'b1, 32'(mv) << 7);
            probe_out(32'hF200_0000, "R3");
        end
        // R7: control write must not disturb enables; single-bit mask
        wr_reg(1'b0, 32'h0000_0020);
        wr_reg(1'b1, 32'hFFFF_FE7F & 32'hFFFF_FEFF);
        probe_out(32'hF280_0000, "R7");
        probe_out(32'hF300_0000, "R2");
        wr_reg(1'b1, 32'h0000_0080);
        probe_out(32'hF280_0000, "R7");

        // random outbound
        for (int i = 0; i < 300; i++) begin
            if (i % 50 == 0) wr_reg(1'b0, $urandom);
            if (i % 75 == 0) wr_reg(1'b1, ((i / 75) % 3 == 2) ? $urandom : 32'h80);
            probe_out(rnd_addr(), "R2");
        end

        // inbound boundaries
        probe_in(32'h0000_0000, "R8");
        probe_in(32'hF07F_FFFF, "R8");
        probe_in(32'hF080_0000, "R9");
        probe_in(32'hFF7F_FFFF, "R9");
        probe_in(32'hFF80_0000, "R11");
        probe_in(32'hFFEF_FFFF, "R11");
        probe_in(32'hFFF0_0000, "R10");
        probe_in(32'hFFFF_FFFE, "R10");
        probe_in(32'hFFFF_FFFF, "R11");
        for (int i = 0; i < 300; i++) probe_in(rnd_addr(), "R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule